// File: doc/BRIEF.md
# Set/Reset Held Burst Controller

This block is a small controller in the asynchronous burst style, modelled in a clocked and sampled form. It watches four inputs: one level input used only as a qualifying condition, and three edge inputs that form bursts. From them it drives two outputs and one internal state bit. Each of these three signals is held by its own generalized C-element. The element goes high when its set cover is true, goes low when its reset cover is true, and keeps its value when neither is true. A short set or reset term that would not change the held value has no effect.

The inputs are resynchronised through a parameterised chain of flops. All three held signals then update together on one clock edge, using the resynchronised inputs and the present held values. A synchronous reset loads the initial state. If the set and reset covers of one signal are both true in the same cycle, that signal keeps its value and a sticky flag is raised, so that a bench or a monitor can spot an illegal burst.

Top module: `gcb_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `out_x`=INIT_X (default 1), `out_y`=INIT_Y (default 0), `out_z`=INIT_Z (default 0), with `conflict_o`=0 and every resynchroniser flop at 0.
- R2: A change on the inputs reaches the held signals exactly SYNC_STAGES+1 rising edges after it is applied. Before that edge, the outputs show no effect of the change.
- R3: Using the resynchronised inputs and the present state, the x set cover is !b&!d&!y | !b&c&!y | !b&d&a&y, and the x reset cover is b&d&!z | !c&!d&z.
- R4: The y set cover is b&d&!z, and the y reset cover is b&!c&z | b&c&a.
- R5: The z set cover is !b&d&y&a, and the z reset cover is !b&c&!y.
- R6: A signal whose set and reset covers are both false keeps its value across the edge.
- R7: A signal whose set and reset covers are both true keeps its value. `conflict_o` then rises and stays at 1 until a reset, and the other signals still update normally.
- R8: From the state x=0, y=0, z=1 with inputs a=1, b=0, c=0, d=1, the burst c rising alone, or c rising together with d falling, drives x to 1 and z to 0 with no conflict. d falling alone is a conflict on x, so x holds at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | Level-sensitive qualifying input |
| in_b | input | 1 | Edge-sensitive burst input |
| in_c | input | 1 | Edge-sensitive burst input |
| in_d | input | 1 | Edge-sensitive burst input |
| out_x | output | 1 | Held output x |
| out_y | output | 1 | Held output y |
| out_z | output | 1 | Held internal state variable z |
| conflict_o | output | 1 | Sticky flag: set and reset true together on some signal |

## Verification
The bench builds the block with SYNC_STAGES=3 and the default initial state. This gives a four-edge window between an input change and its effect, so a check can confirm that the outputs stay still on every edge before the update, not only on the edge where the update happens. With these values the bench can walk a burst sequence into the state where x has fallen while z is high. From there it drives the OR-type burst both alone and combined, and it also drives the lone d fall that makes the x covers collide. That last case shows the hold and the sticky flag together.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

    localparam int NSIG  = 3;
    localparam int IDX_X = 0;
    localparam int IDX_Y = 1;
    localparam int IDX_Z = 2;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } gcb_in_t;

    localparam int IN_W = $bits(gcb_in_t);

    typedef logic [NSIG-1:0] gcb_vec_t;

endpackage

// File: rtl/gcb_sync.sv
module gcb_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gcb_cover.sv
module gcb_cover
    import gcb_pkg::*;
(
    input  gcb_in_t  smp,
    input  gcb_vec_t cur,
    output gcb_vec_t set_v,
    output gcb_vec_t clr_v
);
    logic x, y, z;

    always_comb begin
        x = cur[IDX_X];
        y = cur[IDX_Y];
        z = cur[IDX_Z];

        // x covers (R3)
        set_v[IDX_X] = (!smp.b && !smp.d && !y)
                     | (!smp.b &&  smp.c && !y)
                     | (!smp.b &&  smp.d && smp.a && y);
        clr_v[IDX_X] = ( smp.b &&  smp.d && !z)
                     | (!smp.c && !smp.d &&  z);

        // y covers (R4)
        set_v[IDX_Y] = smp.b && smp.d && !z;
        clr_v[IDX_Y] = (smp.b && !smp.c && z)
                     | (smp.b &&  smp.c && smp.a);

        // z covers (R5)
        set_v[IDX_Z] = !smp.b && smp.d && y && smp.a;
        clr_v[IDX_Z] = !smp.b && smp.c && !y;
        if (x) begin
            // x is read by no cover; kept for symmetry of the state view
        end
    end

endmodule

// File: rtl/gcb_celem_bank.sv
module gcb_celem_bank #(
    parameter int              N    = 3,
    parameter logic [N-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] val_q,
    output logic [N-1:0] clash_v
);
    for (genvar g = 0; g < N; g++) begin : g_elem
        typedef struct packed {
            logic val;
        } elem_t;

        elem_t e_d, e_q;

        always_comb begin
            e_d        = e_q;
            clash_v[g] = set_v[g] && clr_v[g];
            if (set_v[g] && !clr_v[g]) begin
                e_d.val = 1'b1;
            end else if (clr_v[g] && !set_v[g]) begin
                e_d.val = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                e_q.val <= INIT[g];
            end else begin
                e_q <= e_d;
            end
        end

        assign val_q[g] = e_q.val;
    end

endmodule

// File: rtl/gcb_ctrl.sv
module gcb_ctrl
    import gcb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit INIT_X      = 1'b1,
    parameter bit INIT_Y      = 1'b0,
    parameter bit INIT_Z      = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    input  logic in_d,
    output logic out_x,
    output logic out_y,
    output logic out_z,
    output logic conflict_o
);
    localparam gcb_vec_t INIT_V = {INIT_Z, INIT_Y, INIT_X};

    typedef struct packed {
        logic conflict;
    } flag_t;

    gcb_in_t  raw_in;
    gcb_in_t  smp_in;
    gcb_vec_t set_v;
    gcb_vec_t clr_v;
    gcb_vec_t state_q;
    gcb_vec_t clash_v;
    flag_t    flag_d, flag_q;

    always_comb begin
        raw_in.a = in_a;
        raw_in.b = in_b;
        raw_in.c = in_c;
        raw_in.d = in_d;
    end

    gcb_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (smp_in)
    );

    gcb_cover u_cover (
        .smp   (smp_in),
        .cur   (state_q),
        .set_v (set_v),
        .clr_v (clr_v)
    );

    gcb_celem_bank #(
        .N    (NSIG),
        .INIT (INIT_V)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_v   (set_v),
        .clr_v   (clr_v),
        .val_q   (state_q),
        .clash_v (clash_v)
    );

    always_comb begin
        flag_d = flag_q;
        if (|clash_v) begin
            flag_d.conflict = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign out_x      = state_q[IDX_X];
    assign out_y      = state_q[IDX_Y];
    assign out_z      = state_q[IDX_Z];
    assign conflict_o = flag_q.conflict;

endmodule

// File: rtl/gcb_checker.sv
module gcb_checker #(
    parameter int       N    = 3,
    parameter bit [2:0] INIT = 3'b001
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] set_v,
    input logic [N-1:0] clr_v,
    input logic [N-1:0] state,
    input logic         conflict
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (state == INIT[N-1:0] && !conflict));

    a_r7_sticky_flag: assert property (@(posedge clk) disable iff (rst)
        conflict |=> conflict);

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R3 R4 R5: lone set raises, lone reset lowers
        a_r3_lone_set: assert property (@(posedge clk) disable iff (rst)
            (set_v[g] && !clr_v[g]) |=> state[g]);
        a_r3_lone_clr: assert property (@(posedge clk) disable iff (rst)
            (clr_v[g] && !set_v[g]) |=> !state[g]);
        a_r6_hold: assert property (@(posedge clk) disable iff (rst)
            (!set_v[g] && !clr_v[g]) |=> $stable(state[g]));
        a_r7_clash_hold: assert property (@(posedge clk) disable iff (rst)
            (set_v[g] && clr_v[g]) |=> ($stable(state[g]) && conflict));
    end

endmodule

bind gcb_ctrl gcb_checker #(
    .N    (gcb_pkg::NSIG),
    .INIT ({INIT_Z, INIT_Y, INIT_X})
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .set_v    (set_v),
    .clr_v    (clr_v),
    .state    (state_q),
    .conflict (conflict_o)
);

// File: tb/gcb_ctrl_tb.sv
module gcb_ctrl_tb;
    localparam int SYNC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b0, b = 1'b0, c = 1'b0, d = 1'b0;
    logic x, y, z, cf;

    int compared   = 0;
    int mismatched = 0;
    bit started    = 0;
    bit done       = 0;

    always #2 clk = ~clk;

    gcb_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst), .in_a(a), .in_b(b), .in_c(c), .in_d(d),
        .out_x(x), .out_y(y), .out_z(z), .conflict_o(cf)
    );

    // Behavioural reference: queue of sampled inputs, equations from R3..R5
    logic mx, my, mz, mcf;
    logic [3:0] pipe [$];

    always @(posedge clk) begin
        logic [3:0] o;
        logic sa, sb, sc, sd, xs, xr, ys, yr, zs, zr;
        started = 1;
        if (rst) begin
            mx = 1; my = 0; mz = 0; mcf = 0;
            pipe.delete();
            for (int i = 0; i < SYNC; i++) pipe.push_back(4'b0);
        end else begin
            o = pipe.pop_front();
            {sa, sb, sc, sd} = o;
            xs = (!sb && !sd && !my) || (!sb && sc && !my) || (!sb && sd && sa && my);
            xr = (sb && sd && !mz) || (!sc && !sd && mz);
            ys = sb && sd && !mz;
            yr = (sb && !sc && mz) || (sb && sc && sa);
            zs = !sb && sd && my && sa;
            zr = !sb && sc && !my;
            if (xs && xr) mcf = 1; else if (xs) mx = 1; else if (xr) mx = 0;
            if (ys && yr) mcf = 1; else if (ys) my = 1; else if (yr) my = 0;
            if (zs && zr) mcf = 1; else if (zs) mz = 1; else if (zr) mz = 0;
            pipe.push_back({a, b, c, d});
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            compared++;
            if ({x, y, z, cf} !== {mx, my, mz, mcf}) begin
                mismatched++;
                $display("FAIL R3/R4/R5/R6/R7 model: got xyzf=%b%b%b%b expected %b%b%b%b",
                         x, y, z, cf, mx, my, mz, mcf);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v);
        @(negedge clk);
        {a, b, c, d} = v;
    endtask

    task automatic settle();
        repeat (SYNC + 2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        {a, b, c, d} = 4'b0000;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    // walk into x=0 y=0 z=1 with a=1 b=0 c=0 d=1
    task automatic reach_or_state();
        drive(4'b0101); settle();
        chk("R4 y set", y, 1'b1); chk("R3 x reset", x, 1'b0);
        drive(4'b1001); settle();
        chk("R5 z set", z, 1'b1); chk("R3 x set via a", x, 1'b1);
        drive(4'b1000); settle();
        chk("R3 x reset via z", x, 1'b0); chk("R6 y hold", y, 1'b1);
        drive(4'b1100); settle();
        chk("R4 y reset", y, 1'b0);
        drive(4'b1101); settle();
        chk("R6 y blocked by z", y, 1'b0);
        drive(4'b1001); settle();
        chk("R6 x hold", x, 1'b0); chk("R6 z hold", z, 1'b1); chk("R6 y hold", y, 1'b0);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 x init", x, 1'b1); chk("R1 y init", y, 1'b0);
        chk("R1 z init", z, 1'b0); chk("R1 flag clear", cf, 1'b0);

        // OR burst, c rising alone, with latency window (R2, R8)
        reach_or_state();
        drive(4'b1011);
        for (int k = 0; k < SYNC; k++) begin
            @(negedge clk);
            chk("R2 x still old", x, 1'b0);
        end
        @(negedge clk);
        chk("R2 R8 x rises on c", x, 1'b1);
        chk("R8 z falls", z, 1'b0);
        chk("R8 no conflict", cf, 1'b0);

        // d falling alone: conflict on x (R7, R8)
        reach_or_state();
        drive(4'b1000); settle();
        chk("R7 R8 x holds on clash", x, 1'b0);
        chk("R7 flag raised", cf, 1'b1);
        chk("R7 z unaffected", z, 1'b1);
        drive(4'b1010); settle();
        chk("R7 x updates later", x, 1'b1);
        chk("R7 flag sticky", cf, 1'b1);

        // reset clears flag (R1)
        do_reset();
        @(negedge clk);
        chk("R1 flag cleared", cf, 1'b0);
        chk("R1 x reinit", x, 1'b1);

        // c rising with d falling together (R8)
        reach_or_state();
        drive(4'b1010); settle();
        chk("R8 combined x", x, 1'b1);
        chk("R8 combined z", z, 1'b0);
        chk("R8 combined no conflict", cf, 1'b0);

        settle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule